// File: doc/BRIEF.md
# Miss Target List

This block holds the requests that are waiting on one outstanding cache miss. Each accepted request becomes a target in a short ordered list. A target stores five things: a command code, a source tag, an order number, a ready time and a marked-pending bit. Targets leave the list from the head in the order they arrived.

While targets are appended, the list keeps two summary flags:

- `needs_writable` says that some non-snoop target asks for a writable copy of the line.
- `has_upgrade` says that some non-snoop target is an upgrade-style request.

When the miss handler learns that the line held for an upgrade has been lost, it pulses `rewrite`. In that same clock, every upgrade-style command in the list becomes its fallback form. Two more strobes act on the flags only: one clears them, and one rebuilds them from the targets currently held.

Command codes:

| Code | Command | Needs writable | Upgrade-style |
|---|---|---|---|
| 0 | read shared | no | no |
| 1 | read exclusive | yes | no |
| 2 | upgrade | yes | yes |
| 3 | store-conditional upgrade | yes | yes |
| 4 | store-conditional | yes | yes |
| 5 | store-conditional upgrade fail | yes | no |
| 6 | store-conditional fail | yes | no |
| 7 to 15 | any other | no | no |

Source tags are 0 for CPU, 1 for snoop and 2 for prefetcher.

Top module: `miss_target_list`

## Requirements
- R1: After reset, `count` is 0, `empty` is 1, `full` is 0, and `needs_writable`, `has_upgrade` and `overflow_err` are all 0.
- R2: Targets pop in the order they were pushed. The head outputs show the command, source, order number, ready time and marked-pending bit of the oldest target exactly as they were pushed, unless a rewrite has changed the command.
- R3: A push while `full` is 1 is refused. `overflow_err` is 1 for exactly the one cycle after that push. The count and the stored targets do not change, and the flags do not change.
- R4: An accepted push whose source is not snoop (1) and whose command is one of codes 1 to 6 sets `needs_writable` from the next cycle. `needs_writable` then stays set until a flag-clear or flag-rebuild strobe.
- R5: An accepted push whose source is not snoop and whose command is 2, 3 or 4 sets `has_upgrade` from the next cycle.
- R6: An accepted push with source snoop (1) changes neither flag, whatever its command.
- R7: A `rewrite` pulse while `has_upgrade` is 1 changes every held command in one clock: 2 becomes 1, 3 becomes 5 and 4 becomes 6. All other codes are kept. `has_upgrade` is 0 in the next cycle, unless a push in the same cycle sets it again.
- R8: A `rewrite` pulse while `has_upgrade` is 0 leaves every stored command unchanged.
- R9: A `flags_reset` pulse makes both flags 0 in the next cycle. It overrides every other flag update in that cycle.
- R10: A `flags_recompute` pulse sets each flag to its summary over the targets held after that cycle's pop, push and rewrite. Snoop targets are left out of the summary.
- R11: `pop` removes the head target. A pop on an empty list is ignored. A pop never changes either flag.
- R12: When strobes coincide, the flags follow this priority: `flags_reset` first, then `flags_recompute`, then the rewrite clear together with push setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Append a target this cycle |
| push_cmd | input | 4 | Command code of the new target |
| push_src | input | 2 | Source tag of the new target (0 CPU, 1 snoop, 2 prefetcher) |
| push_order | input | ORDER_W | Order number of the new target |
| push_ready_time | input | TIME_W | Ready time of the new target |
| push_mark | input | 1 | Marked-pending bit of the new target |
| pop | input | 1 | Remove the head target |
| rewrite | input | 1 | Change every upgrade-style command to its fallback |
| flags_reset | input | 1 | Clear both summary flags |
| flags_recompute | input | 1 | Rebuild both flags from the held targets |
| count | output | clog2(DEPTH+1) | Number of targets held |
| empty | output | 1 | No targets held |
| full | output | 1 | DEPTH targets held |
| head_cmd | output | 4 | Command of the oldest target |
| head_src | output | 2 | Source of the oldest target |
| head_order | output | ORDER_W | Order number of the oldest target |
| head_ready_time | output | TIME_W | Ready time of the oldest target |
| head_mark | output | 1 | Marked-pending bit of the oldest target |
| needs_writable | output | 1 | Some counted target needs a writable copy |
| has_upgrade | output | 1 | Some counted target is upgrade-style |
| overflow_err | output | 1 | One-cycle pulse after a refused push |

## Verification
The assertions assume that every strobe and push field is a known value at each rising edge after reset. They also assume that `push_src` carries only the three defined source codes.

Some properties isolate a single effect, such as a snoop push leaving the flags alone or a rewrite with nothing to change. Those properties fire only when the other strobes are low in that cycle.

The bench changes inputs only on falling edges. It uses source codes 0 to 2 only. It raises several strobes together only in the scenario written for the priority rule.

// File: rtl/mtl_pkg.sv
package mtl_pkg;

  localparam int CMD_W = 4;
  localparam int SRC_W = 2;

  localparam logic [CMD_W-1:0] CMD_RD_SHARED   = 4'd0;
  localparam logic [CMD_W-1:0] CMD_RD_EXCL     = 4'd1;
  localparam logic [CMD_W-1:0] CMD_UPGRADE     = 4'd2;
  localparam logic [CMD_W-1:0] CMD_SC_UPGRADE  = 4'd3;
  localparam logic [CMD_W-1:0] CMD_STORE_COND  = 4'd4;
  localparam logic [CMD_W-1:0] CMD_SC_UPG_FAIL = 4'd5;
  localparam logic [CMD_W-1:0] CMD_SC_FAIL     = 4'd6;

  localparam logic [SRC_W-1:0] SRC_CPU      = 2'd0;
  localparam logic [SRC_W-1:0] SRC_SNOOP    = 2'd1;
  localparam logic [SRC_W-1:0] SRC_PREFETCH = 2'd2;

  // Commands that ask for a writable copy of the line
  function automatic logic cmd_needs_writable(input logic [CMD_W-1:0] c);
    return (c >= CMD_RD_EXCL) && (c <= CMD_SC_FAIL);
  endfunction

  // Upgrade-style commands, store-conditional included
  function automatic logic cmd_is_upgrade(input logic [CMD_W-1:0] c);
    return (c == CMD_UPGRADE) || (c == CMD_SC_UPGRADE) || (c == CMD_STORE_COND);
  endfunction

  // Fallback command once the line held for the upgrade is gone
  function automatic logic [CMD_W-1:0] cmd_fallback(input logic [CMD_W-1:0] c);
    case (c)
      CMD_UPGRADE:    return CMD_RD_EXCL;
      CMD_SC_UPGRADE: return CMD_SC_UPG_FAIL;
      CMD_STORE_COND: return CMD_SC_FAIL;
      default:        return c;
    endcase
  endfunction

  // Snoop targets never contribute to the summary flags
  function automatic logic src_counts(input logic [SRC_W-1:0] s);
    return s != SRC_SNOOP;
  endfunction

endpackage

// File: rtl/mtl_entry_store.sv
module mtl_entry_store
  import mtl_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int ORDER_W = 8,
  parameter int TIME_W  = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push_fire,
  input  logic [CMD_W-1:0]               push_cmd,
  input  logic [SRC_W-1:0]               push_src,
  input  logic [ORDER_W-1:0]             push_order,
  input  logic [TIME_W-1:0]              push_ready_time,
  input  logic                           push_mark,
  input  logic                           pop_fire,
  input  logic                           rewrite_fire,
  output logic [CNT_W-1:0]               cnt_q,
  output logic [CMD_W-1:0]               head_cmd,
  output logic [SRC_W-1:0]               head_src,
  output logic [ORDER_W-1:0]             head_order,
  output logic [TIME_W-1:0]              head_ready_time,
  output logic                           head_mark,
  output logic [DEPTH-1:0][CMD_W-1:0]    nxt_cmd,
  output logic [DEPTH-1:0][SRC_W-1:0]    nxt_src,
  output logic [DEPTH-1:0]               nxt_valid
);

  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W-1:0] wr_idx;

  logic [DEPTH-1:0][CMD_W-1:0]   cur_cmd;
  logic [DEPTH-1:0][CMD_W-1:0]   rw_cmd;
  logic [DEPTH-1:0][SRC_W-1:0]   cur_src;
  logic [DEPTH-1:0][ORDER_W-1:0] cur_ord;
  logic [DEPTH-1:0][TIME_W-1:0]  cur_time;
  logic [DEPTH-1:0]              cur_mark;

  // The write slot sits just past the last entry kept after any pop
  assign wr_idx = cnt_q - CNT_W'(pop_fire);
  assign cnt_n  = cnt_q - CNT_W'(pop_fire) + CNT_W'(push_fire);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam int NB = (g < DEPTH - 1) ? g + 1 : g;

    logic [CMD_W-1:0]   cmd_q,  cmd_n;
    logic [SRC_W-1:0]   src_q,  src_n;
    logic [ORDER_W-1:0] ord_q,  ord_n;
    logic [TIME_W-1:0]  time_q, time_n;
    logic               mark_q, mark_n;
    logic               take_push;

    assign cur_cmd[g]  = cmd_q;
    assign cur_src[g]  = src_q;
    assign cur_ord[g]  = ord_q;
    assign cur_time[g] = time_q;
    assign cur_mark[g] = mark_q;

    // Every slot rewrites its own command in parallel
    assign rw_cmd[g]  = rewrite_fire ? cmd_fallback(cur_cmd[g]) : cur_cmd[g];
    assign take_push  = push_fire && (wr_idx == CNT_W'(g));

    always_comb begin
      cmd_n  = rw_cmd[g];
      src_n  = cur_src[g];
      ord_n  = cur_ord[g];
      time_n = cur_time[g];
      mark_n = cur_mark[g];
      if (pop_fire) begin
        cmd_n  = rw_cmd[NB];
        src_n  = cur_src[NB];
        ord_n  = cur_ord[NB];
        time_n = cur_time[NB];
        mark_n = cur_mark[NB];
      end
      if (take_push) begin
        cmd_n  = push_cmd;
        src_n  = push_src;
        ord_n  = push_order;
        time_n = push_ready_time;
        mark_n = push_mark;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmd_q  <= '0;
        src_q  <= '0;
        ord_q  <= '0;
        time_q <= '0;
        mark_q <= 1'b0;
      end else begin
        cmd_q  <= cmd_n;
        src_q  <= src_n;
        ord_q  <= ord_n;
        time_q <= time_n;
        mark_q <= mark_n;
      end
    end

    assign nxt_cmd[g]   = cmd_n;
    assign nxt_src[g]   = src_n;
    assign nxt_valid[g] = (CNT_W'(g) < cnt_n);
  end

  assign head_cmd        = cur_cmd[0];
  assign head_src        = cur_src[0];
  assign head_order      = cur_ord[0];
  assign head_ready_time = cur_time[0];
  assign head_mark       = cur_mark[0];

endmodule

// File: rtl/mtl_flag_unit.sv
module mtl_flag_unit
  import mtl_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flags_reset,
  input  logic                        flags_recompute,
  input  logic                        rewrite_fire,
  input  logic                        push_fire,
  input  logic [CMD_W-1:0]            push_cmd,
  input  logic [SRC_W-1:0]            push_src,
  input  logic [DEPTH-1:0][CMD_W-1:0] nxt_cmd,
  input  logic [DEPTH-1:0][SRC_W-1:0] nxt_src,
  input  logic [DEPTH-1:0]            nxt_valid,
  output logic                        needs_writable_q,
  output logic                        has_upgrade_q
);

  logic sum_nw, sum_hu;
  logic push_counts;
  logic nw_n, hu_n;

  // Summary over the contents the list will hold after this edge
  always_comb begin
    sum_nw = 1'b0;
    sum_hu = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (nxt_valid[i] && src_counts(nxt_src[i])) begin
        sum_nw = sum_nw | cmd_needs_writable(nxt_cmd[i]);
        sum_hu = sum_hu | cmd_is_upgrade(nxt_cmd[i]);
      end
    end
  end

  assign push_counts = push_fire && src_counts(push_src);

  always_comb begin
    if (flags_reset) begin
      nw_n = 1'b0;
      hu_n = 1'b0;
    end else if (flags_recompute) begin
      nw_n = sum_nw;
      hu_n = sum_hu;
    end else begin
      nw_n = needs_writable_q | (push_counts && cmd_needs_writable(push_cmd));
      hu_n = (has_upgrade_q && !rewrite_fire) | (push_counts && cmd_is_upgrade(push_cmd));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      needs_writable_q <= 1'b0;
      has_upgrade_q    <= 1'b0;
    end else begin
      needs_writable_q <= nw_n;
      has_upgrade_q    <= hu_n;
    end
  end

endmodule

// File: rtl/miss_target_list.sv
module miss_target_list
  import mtl_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int ORDER_W = 8,
  parameter int TIME_W  = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  input  logic [3:0]         push_cmd,
  input  logic [1:0]         push_src,
  input  logic [ORDER_W-1:0] push_order,
  input  logic [TIME_W-1:0]  push_ready_time,
  input  logic               push_mark,
  input  logic               pop,
  input  logic               rewrite,
  input  logic               flags_reset,
  input  logic               flags_recompute,
  output logic [CNT_W-1:0]   count,
  output logic               empty,
  output logic               full,
  output logic [3:0]         head_cmd,
  output logic [1:0]         head_src,
  output logic [ORDER_W-1:0] head_order,
  output logic [TIME_W-1:0]  head_ready_time,
  output logic               head_mark,
  output logic               needs_writable,
  output logic               has_upgrade,
  output logic               overflow_err
);

  // Named internal events, visible to the checker
  logic push_fire, push_refused, pop_fire, rewrite_fire;
  logic [DEPTH-1:0][CMD_W-1:0] nxt_cmd;
  logic [DEPTH-1:0][SRC_W-1:0] nxt_src;
  logic [DEPTH-1:0]            nxt_valid;
  logic                        err_q;

  assign full         = (count == CNT_W'(DEPTH));
  assign empty        = (count == '0);
  assign push_fire    = push_valid && !full;
  assign push_refused = push_valid && full;
  assign pop_fire     = pop && !empty;
  assign rewrite_fire = rewrite && has_upgrade;

  mtl_entry_store #(
    .DEPTH   (DEPTH),
    .ORDER_W (ORDER_W),
    .TIME_W  (TIME_W)
  ) u_store (
    .clk             (clk),
    .rst_n           (rst_n),
    .push_fire       (push_fire),
    .push_cmd        (push_cmd),
    .push_src        (push_src),
    .push_order      (push_order),
    .push_ready_time (push_ready_time),
    .push_mark       (push_mark),
    .pop_fire        (pop_fire),
    .rewrite_fire    (rewrite_fire),
    .cnt_q           (count),
    .head_cmd        (head_cmd),
    .head_src        (head_src),
    .head_order      (head_order),
    .head_ready_time (head_ready_time),
    .head_mark       (head_mark),
    .nxt_cmd         (nxt_cmd),
    .nxt_src         (nxt_src),
    .nxt_valid       (nxt_valid)
  );

  mtl_flag_unit #(
    .DEPTH (DEPTH)
  ) u_flags (
    .clk              (clk),
    .rst_n            (rst_n),
    .flags_reset      (flags_reset),
    .flags_recompute  (flags_recompute),
    .rewrite_fire     (rewrite_fire),
    .push_fire        (push_fire),
    .push_cmd         (push_cmd),
    .push_src         (push_src),
    .nxt_cmd          (nxt_cmd),
    .nxt_src          (nxt_src),
    .nxt_valid        (nxt_valid),
    .needs_writable_q (needs_writable),
    .has_upgrade_q    (has_upgrade)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= push_refused;
  end

  assign overflow_err = err_q;

endmodule

// File: rtl/mtl_checker.sv
module mtl_checker
  import mtl_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic [3:0]       push_cmd,
  input logic [1:0]       push_src,
  input logic             pop,
  input logic             rewrite,
  input logic             flags_reset,
  input logic             flags_recompute,
  input logic [CNT_W-1:0] count,
  input logic             full,
  input logic             empty,
  input logic [3:0]       head_cmd,
  input logic             needs_writable,
  input logic             has_upgrade,
  input logic             overflow_err
);

  a_r3_refused_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && full |=> overflow_err);

  a_r3_no_spurious_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid && full) |=> !overflow_err);

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && full && !pop |=> full && $stable(count));

  a_r4_writable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    needs_writable && !flags_reset && !flags_recompute |=> needs_writable);

  a_r6_snoop_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && (push_src == SRC_SNOOP) && !flags_reset && !flags_recompute && !rewrite
    |=> $stable(needs_writable) && $stable(has_upgrade));

  a_r7_rewrite_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rewrite && has_upgrade && !flags_recompute &&
    !(push_valid && !full && (push_src != SRC_SNOOP) && cmd_is_upgrade(push_cmd))
    |=> !has_upgrade);

  a_r8_rewrite_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rewrite && !has_upgrade && !pop && !push_valid |=> $stable(head_cmd));

  a_r9_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
    flags_reset |=> !needs_writable && !has_upgrade);

  a_r11_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push_valid |=> empty);

  a_r11_pop_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push_valid && !rewrite && !flags_reset && !flags_recompute
    |=> $stable(needs_writable) && $stable(has_upgrade));

endmodule

bind miss_target_list mtl_checker #(.DEPTH(DEPTH)) u_mtl_chk (.*);

// File: tb/miss_target_list_test.sv
`timescale 1ns/1ps
module miss_target_list_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [3:0]  push_cmd = '0;
  logic [1:0]  push_src = '0;
  logic [7:0]  push_order = '0;
  logic [15:0] push_ready_time = '0;
  logic        push_mark = 1'b0;
  logic        pop = 1'b0;
  logic        rewrite = 1'b0;
  logic        flags_reset = 1'b0;
  logic        flags_recompute = 1'b0;
  logic [2:0]  count;
  logic        empty, full;
  logic [3:0]  head_cmd;
  logic [1:0]  head_src;
  logic [7:0]  head_order;
  logic [15:0] head_ready_time;
  logic        head_mark;
  logic        needs_writable, has_upgrade, overflow_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  miss_target_list uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_cmd(push_cmd),
    .push_src(push_src), .push_order(push_order), .push_ready_time(push_ready_time),
    .push_mark(push_mark), .pop(pop), .rewrite(rewrite), .flags_reset(flags_reset),
    .flags_recompute(flags_recompute), .count(count), .empty(empty), .full(full),
    .head_cmd(head_cmd), .head_src(head_src), .head_order(head_order),
    .head_ready_time(head_ready_time), .head_mark(head_mark),
    .needs_writable(needs_writable), .has_upgrade(has_upgrade),
    .overflow_err(overflow_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic push1(input logic [3:0] c, input logic [1:0] s, input logic [7:0] o,
                       input logic [15:0] t, input logic m);
    push_valid = 1'b1; push_cmd = c; push_src = s;
    push_order = o; push_ready_time = t; push_mark = m;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pop1();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic pop_expect(input string tag, input logic [3:0] c, input logic [1:0] s,
                            input logic [7:0] o, input logic [15:0] t, input logic m);
    chk({tag, " head_cmd"},   32'(head_cmd), 32'(c));
    chk({tag, " head_src"},   32'(head_src), 32'(s));
    chk({tag, " head_order"}, 32'(head_order), 32'(o));
    chk({tag, " head_time"},  32'(head_ready_time), 32'(t));
    chk({tag, " head_mark"},  32'(head_mark), 32'(m));
    pop1();
  endtask

  task automatic pulse_freset();
    flags_reset = 1'b1; @(negedge clk); flags_reset = 1'b0;
  endtask

  task automatic pulse_recomp();
    flags_recompute = 1'b1; @(negedge clk); flags_recompute = 1'b0;
  endtask

  task automatic pulse_rewrite();
    rewrite = 1'b1; @(negedge clk); rewrite = 1'b0;
  endtask

  task automatic flags_are(input string tag, input logic nw, input logic hu);
    chk({tag, " needs_writable"}, 32'(needs_writable), 32'(nw));
    chk({tag, " has_upgrade"},    32'(has_upgrade), 32'(hu));
  endtask

  task automatic t_reset();
    chk("R1 count", 32'(count), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full",  32'(full), 0);
    chk("R1 err",   32'(overflow_err), 0);
    flags_are("R1", 1'b0, 1'b0);
  endtask

  task automatic t_fifo();
    push1(4'd0, 2'd0, 8'h11, 16'h0100, 1'b1);
    push1(4'd7, 2'd2, 8'h22, 16'h0200, 1'b0);
    push1(4'd1, 2'd0, 8'h33, 16'h0300, 1'b1);
    chk("R2 count after three", 32'(count), 3);
    pop_expect("R2 first",  4'd0, 2'd0, 8'h11, 16'h0100, 1'b1);
    pop_expect("R2 second", 4'd7, 2'd2, 8'h22, 16'h0200, 1'b0);
    pop_expect("R2 third",  4'd1, 2'd0, 8'h33, 16'h0300, 1'b1);
    chk("R11 empty after pops", 32'(empty), 1);
    pop1();
    chk("R11 pop on empty count", 32'(count), 0);
    chk("R11 pop on empty full", 32'(full), 0);
  endtask

  task automatic t_flags();
    pulse_freset();
    flags_are("R9 cleared", 1'b0, 1'b0);
    push1(4'd0, 2'd0, 8'h01, 16'h0, 1'b0);
    flags_are("R4 read shared leaves flags", 1'b0, 1'b0);
    push1(4'd2, 2'd1, 8'h02, 16'h0, 1'b0);
    flags_are("R6 snoop upgrade ignored", 1'b0, 1'b0);
    push1(4'd1, 2'd0, 8'h03, 16'h0, 1'b0);
    flags_are("R4 read exclusive", 1'b1, 1'b0);
    push1(4'd4, 2'd2, 8'h04, 16'h0, 1'b0);
    flags_are("R5 store-cond from prefetcher", 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) pop1();
    chk("R11 list drained", 32'(count), 0);
    flags_are("R11 pops keep flags", 1'b1, 1'b1);
    pulse_freset();
    flags_are("R9 clear after fill", 1'b0, 1'b0);
  endtask

  task automatic t_rewrite();
    push1(4'd2, 2'd0, 8'h41, 16'h10, 1'b0);
    push1(4'd3, 2'd1, 8'h42, 16'h20, 1'b1);
    push1(4'd4, 2'd2, 8'h43, 16'h30, 1'b0);
    push1(4'd1, 2'd0, 8'h44, 16'h40, 1'b1);
    flags_are("R7 before rewrite", 1'b1, 1'b1);
    pulse_rewrite();
    flags_are("R7 after rewrite", 1'b1, 1'b0);
    chk("R7 count kept", 32'(count), 4);
    pop_expect("R7 upgrade to read-excl", 4'd1, 2'd0, 8'h41, 16'h10, 1'b0);
    pop_expect("R7 sc-upgrade to fail",   4'd5, 2'd1, 8'h42, 16'h20, 1'b1);
    pop_expect("R7 store-cond to fail",   4'd6, 2'd2, 8'h43, 16'h30, 1'b0);
    pop_expect("R7 read-excl kept",       4'd1, 2'd0, 8'h44, 16'h40, 1'b1);
    pulse_freset();
    push1(4'd2, 2'd1, 8'h50, 16'h50, 1'b0);
    flags_are("R8 snoop upgrade only", 1'b0, 1'b0);
    pulse_rewrite();
    chk("R8 idle rewrite keeps cmd", 32'(head_cmd), 2);
    pop1();
  endtask

  task automatic t_overflow();
    pulse_freset();
    for (int i = 0; i < 4; i++) push1(4'd0, 2'd0, 8'(8'h10 + i), 16'(i), 1'b0);
    chk("R3 full", 32'(full), 1);
    push1(4'd2, 2'd0, 8'h99, 16'hFFFF, 1'b1);
    chk("R3 err pulse", 32'(overflow_err), 1);
    chk("R3 count kept", 32'(count), 4);
    flags_are("R3 refused push sets no flag", 1'b0, 1'b0);
    idle();
    chk("R3 err one cycle", 32'(overflow_err), 0);
    for (int i = 0; i < 4; i++)
      pop_expect("R3 contents kept", 4'd0, 2'd0, 8'(8'h10 + i), 16'(i), 1'b0);
  endtask

  task automatic t_recompute();
    pulse_freset();
    push1(4'd1, 2'd1, 8'h20, 16'h1, 1'b0);
    push1(4'd2, 2'd0, 8'h21, 16'h2, 1'b0);
    flags_are("R10 setup", 1'b1, 1'b1);
    pulse_freset();
    flags_are("R9 before rebuild", 1'b0, 1'b0);
    pulse_recomp();
    flags_are("R10 rebuild skips snoop", 1'b1, 1'b1);
    pop1(); pop1();
    push1(4'd0, 2'd0, 8'h22, 16'h3, 1'b0);
    pulse_recomp();
    flags_are("R10 rebuild on read only", 1'b0, 1'b0);
    push1(4'd4, 2'd0, 8'h23, 16'h4, 1'b1);
    flags_are("R5 store-cond from cpu", 1'b1, 1'b1);
    flags_reset = 1'b1; flags_recompute = 1'b1;
    @(negedge clk);
    flags_reset = 1'b0; flags_recompute = 1'b0;
    flags_are("R12 clear beats rebuild", 1'b0, 1'b0);
    pulse_recomp();
    flags_are("R10 rebuild two entries", 1'b1, 1'b1);
    rewrite = 1'b1; flags_recompute = 1'b1;
    @(negedge clk);
    rewrite = 1'b0; flags_recompute = 1'b0;
    flags_are("R12 rebuild after rewrite", 1'b1, 1'b0);
    pop_expect("R12 first kept",     4'd0, 2'd0, 8'h22, 16'h3, 1'b0);
    pop_expect("R12 second rewritten", 4'd6, 2'd0, 8'h23, 16'h4, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fifo();
    t_flags();
    t_rewrite();
    t_overflow();
    t_recompute();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule